// File: doc/BRIEF.md
# Byte-Command One-Wire Bus Bridge

This block lets a host run a one-wire bus through a byte stream. The host writes command bytes, some followed by one argument byte, on a single-byte write port. It reads one byte at a time from a registered read port. That port always shows the register chosen by an internal selector. Commands can launch a bus reset, a single time slot, an eight-slot byte write or an eight-slot byte read. Other commands write a checked configuration nibble, choose the readable register, or return the block to its start-up state.

Bus activity comes from a bit engine with a cycle counter. It pulls an open-drain line low through an active-high enable and samples the line through a register. Bits travel least significant first. The reset low time, the presence and short sample points, the slot length and the two low times are parameters in clock cycles.

While an operation runs, the status byte shows busy and the block ignores every host byte. Once the operation ends, the status byte holds the presence, short and single-slot results, and a byte read leaves its result in the data register. The host polls status for completion and then moves the selector to fetch data.

Top module: `owb_bridge`

## Requirements
- R1: After reset the line is released, the selector points at status and reads return 0x18 (busy 0, presence 0, short 0, line level 1 in bit3, start-up flag 1 in bit4, bits 5..7 zero). Configuration and data both read 0x00.
- R2: Command 0xD2 with an argument whose bits 7:4 equal the inverse of bits 3:0 stores bits 3:0 as configuration and clears the start-up flag. It also moves the selector to configuration, so the next read returns the nibble with bits 7:4 zero.
- R3: A 0xD2 argument that fails that check changes nothing: configuration, flags and selector keep their values.
- R4: Command 0xE1 followed by 0xC3, 0xE1 or 0xF0 points the selector at configuration, data or status respectively. Any other argument leaves the selector unchanged.
- R5: Status bit0 reads 1 from the cycle after a bus command is accepted until that operation ends. Every host byte written while it is 1 is ignored.
- R6: Command 0xB4 runs a bus reset. Afterwards status bit1 is 1 exactly when the line was low at the presence sample point.
- R7: After a bus reset, status bit2 is 1 exactly when the line was low at the short sample point shortly after release.
- R8: Command 0x87 runs one slot whose written value is argument bit7. The sampled line value is stored in status bit5, so a written 1 acts as a read slot.
- R9: Command 0xA5 sends its argument on the line least significant bit first, as eight slots.
- R10: Command 0x96 runs eight read slots and stores the received byte, first bit in bit0, in the data register, which the host reads after selecting 0xE1.
- R11: Command 0xF0 returns every register, flag and the selector to the R1 values, including start-up flag 1.
- R12: Commands 0xB4, 0x87, 0xA5 and 0x96 move the selector to status.
- R13: A byte in command position that is none of 0x87, 0x96, 0xA5, 0xB4, 0xD2, 0xE1, 0xF0 (for example 0x78 or 0x00) changes nothing.
- R14: A bus reset holds the line low for RSTL cycles. A slot holds it low for LOW1 cycles when writing 1 and LOW0 cycles when writing 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host byte write strobe, one byte per cycle |
| wr_data | input | 8 | Host command or argument byte |
| rd_data | output | 8 | Registered byte of the selected register |
| ow_pull_low | output | 1 | Drive enable that pulls the open-drain line low |
| ow_sense | input | 1 | Level read back from the line |

## Verification
Configuration writes use random argument bytes, half of them forced into the complementary form. This separates the accept and reject paths, and random selector codes separate legal from illegal selections. Random bytes go through byte writes and byte reads with a bus model. A bit-order or shift error shows up there, where a fixed pattern such as 0xFF would hide it. Directed cases cover:
- a bus reset with a device present, one with none, and one with a shorted line, which tell the presence and short flags apart;
- single slots writing 0 and 1 and reading 0 and 1;
- commands sent while busy;
- undefined command bytes;
- a device reset after the start-up flag has been cleared.

// File: rtl/owb_pkg.sv
package owb_pkg;
  localparam logic [7:0] OP_BIT    = 8'h87;
  localparam logic [7:0] OP_RBYTE  = 8'h96;
  localparam logic [7:0] OP_WBYTE  = 8'hA5;
  localparam logic [7:0] OP_BRST   = 8'hB4;
  localparam logic [7:0] OP_WCFG   = 8'hD2;
  localparam logic [7:0] OP_SETPTR = 8'hE1;
  localparam logic [7:0] OP_DRST   = 8'hF0;

  localparam logic [7:0] SEL_CFG  = 8'hC3;
  localparam logic [7:0] SEL_DATA = 8'hE1;
  localparam logic [7:0] SEL_STAT = 8'hF0;

  typedef enum logic [1:0] {RUN_RST, RUN_BIT, RUN_WBYTE, RUN_RBYTE} run_e;
  typedef enum logic [1:0] {E_IDLE, E_RLOW, E_RHIGH, E_SLOT} eng_e;
endpackage

// File: rtl/owb_bit_engine.sv
module owb_bit_engine #(
  parameter int RSTL     = 24000,
  parameter int RSTH     = 24000,
  parameter int SHORT_AT = 100,
  parameter int PRES_AT  = 3500,
  parameter int SLOT     = 3500,
  parameter int LOW0     = 3000,
  parameter int LOW1     = 300,
  parameter int SAMP_AT  = 750
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       start_rst,
  input  logic       start_byte,
  input  logic [7:0] tx,
  input  logic       ow_sense,
  output logic       ow_pull_low,
  output logic       line_lvl,
  output logic       done,
  output logic [7:0] rx,
  output logic       presence,
  output logic       short_flag
);
  import owb_pkg::*;

  localparam int M1   = (RSTL > RSTH) ? RSTL : RSTH;
  localparam int MAXC = (M1 > SLOT) ? M1 : SLOT;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] C_RLOW_END = CW'(RSTL - 1);
  localparam logic [CW-1:0] C_RHI_END  = CW'(RSTH - 1);
  localparam logic [CW-1:0] C_SHORT    = CW'(SHORT_AT);
  localparam logic [CW-1:0] C_PRES     = CW'(PRES_AT);
  localparam logic [CW-1:0] C_SLOT_END = CW'(SLOT - 1);
  localparam logic [CW-1:0] C_LOW0     = CW'(LOW0);
  localparam logic [CW-1:0] C_LOW1     = CW'(LOW1);
  localparam logic [CW-1:0] C_SAMP     = CW'(SAMP_AT);

  eng_e          state;
  logic [CW-1:0] cnt;
  logic [7:0]    sh;
  logic [2:0]    left;
  logic          pull_d;

  always_comb begin
    pull_d = (state == E_RLOW) ||
             ((state == E_SLOT) && (cnt < (sh[0] ? C_LOW1 : C_LOW0)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= E_IDLE;
      cnt         <= '0;
      sh          <= '0;
      left        <= '0;
      rx          <= '0;
      presence    <= 1'b0;
      short_flag  <= 1'b0;
      done        <= 1'b0;
      ow_pull_low <= 1'b0;
      line_lvl    <= 1'b1;
    end else begin
      done        <= 1'b0;
      line_lvl    <= ow_sense;
      ow_pull_low <= pull_d;
      case (state)
        E_IDLE: if (start) begin
          cnt <= '0;
          if (start_rst) state <= E_RLOW;
          else begin
            state <= E_SLOT;
            sh    <= tx;
            left  <= start_byte ? 3'd7 : 3'd0;
          end
        end
        E_RLOW: begin
          if (cnt == C_RLOW_END) begin
            state <= E_RHIGH;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        E_RHIGH: begin
          if (cnt == C_SHORT) short_flag <= !line_lvl;
          if (cnt == C_PRES)  presence   <= !line_lvl;
          if (cnt == C_RHI_END) begin
            state <= E_IDLE;
            done  <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == C_SAMP) rx <= {line_lvl, rx[7:1]};
          if (cnt == C_SLOT_END) begin
            cnt <= '0;
            if (left == 3'd0) begin
              state <= E_IDLE;
              done  <= 1'b1;
            end else begin
              left <= left - 1'b1;
              sh   <= {1'b0, sh[7:1]};
            end
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/owb_cmd_ctrl.sv
module owb_cmd_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       eng_done,
  input  logic [7:0] eng_rx,
  input  logic       eng_pres,
  input  logic       eng_short,
  input  logic       line_lvl,
  output logic       eng_start,
  output logic       eng_is_rst,
  output logic       eng_is_byte,
  output logic [7:0] eng_tx,
  output logic       busy_q,
  output logic [7:0] ptr_q,
  output logic [3:0] cfg_q,
  output logic [7:0] data_q,
  output logic [7:0] status
);
  import owb_pkg::*;

  run_e       run_kind;
  logic       arg_wait;
  logic [7:0] arg_cmd;
  logic       ppd_q, sd_q, sbr_q, rstf_q;
  logic       take, go, dev_rst, cfg_ok, ptr_ok;
  run_e       go_kind;
  logic [7:0] go_tx;

  assign take    = wr_valid && !busy_q;
  assign dev_rst = take && !arg_wait && (wr_data == OP_DRST);
  assign cfg_ok  = (wr_data[7:4] == ~wr_data[3:0]);
  assign ptr_ok  = (wr_data == SEL_CFG) || (wr_data == SEL_DATA) || (wr_data == SEL_STAT);

  always_comb begin
    go      = 1'b0;
    go_kind = RUN_RST;
    go_tx   = 8'hFF;
    if (take) begin
      if (arg_wait) begin
        if (arg_cmd == OP_BIT) begin
          go = 1'b1; go_kind = RUN_BIT; go_tx = {7'b0, wr_data[7]};
        end else if (arg_cmd == OP_WBYTE) begin
          go = 1'b1; go_kind = RUN_WBYTE; go_tx = wr_data;
        end
      end else if (wr_data == OP_RBYTE) begin
        go = 1'b1; go_kind = RUN_RBYTE;
      end else if (wr_data == OP_BRST) begin
        go = 1'b1; go_kind = RUN_RST;
      end
    end
  end

  assign eng_is_rst  = (run_kind == RUN_RST);
  assign eng_is_byte = (run_kind == RUN_WBYTE) || (run_kind == RUN_RBYTE);
  assign status      = {2'b00, sbr_q, rstf_q, line_lvl, sd_q, ppd_q, busy_q};

  always_ff @(posedge clk) begin
    if (rst || dev_rst) begin
      run_kind  <= RUN_RST;
      arg_wait  <= 1'b0;
      arg_cmd   <= '0;
      eng_start <= 1'b0;
      eng_tx    <= '0;
      busy_q    <= 1'b0;
      ptr_q     <= SEL_STAT;
      cfg_q     <= '0;
      data_q    <= '0;
      ppd_q     <= 1'b0;
      sd_q      <= 1'b0;
      sbr_q     <= 1'b0;
      rstf_q    <= 1'b1;
    end else begin
      eng_start <= go;
      if (go) begin
        busy_q   <= 1'b1;
        run_kind <= go_kind;
        eng_tx   <= go_tx;
        ptr_q    <= SEL_STAT;
      end
      if (eng_done) begin
        busy_q <= 1'b0;
        case (run_kind)
          RUN_RST:   begin ppd_q <= eng_pres; sd_q <= eng_short; end
          RUN_BIT:   sbr_q  <= eng_rx[7];
          RUN_RBYTE: data_q <= eng_rx;
          default:   ;
        endcase
      end
      if (take) begin
        if (arg_wait) begin
          arg_wait <= 1'b0;
          if (arg_cmd == OP_WCFG && cfg_ok) begin
            cfg_q  <= wr_data[3:0];
            rstf_q <= 1'b0;
            ptr_q  <= SEL_CFG;
          end else if (arg_cmd == OP_SETPTR && ptr_ok) begin
            ptr_q <= wr_data;
          end
        end else if (wr_data == OP_BIT || wr_data == OP_WBYTE ||
                     wr_data == OP_WCFG || wr_data == OP_SETPTR) begin
          arg_wait <= 1'b1;
          arg_cmd  <= wr_data;
        end
      end
    end
  end
endmodule

// File: rtl/owb_bridge.sv
module owb_bridge #(
  parameter int RSTL     = 24000,
  parameter int RSTH     = 24000,
  parameter int SHORT_AT = 100,
  parameter int PRES_AT  = 3500,
  parameter int SLOT     = 3500,
  parameter int LOW0     = 3000,
  parameter int LOW1     = 300,
  parameter int SAMP_AT  = 750
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       ow_pull_low,
  input  logic       ow_sense
);
  import owb_pkg::*;

  logic       eng_start, eng_is_rst, eng_is_byte, eng_done, eng_pres, eng_short, line_lvl;
  logic [7:0] eng_tx, eng_rx;
  logic       ctl_busy;
  logic [7:0] rd_ptr, data_q, status;
  logic [3:0] cfg_q;

  owb_cmd_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .eng_done(eng_done), .eng_rx(eng_rx), .eng_pres(eng_pres), .eng_short(eng_short),
    .line_lvl(line_lvl), .eng_start(eng_start), .eng_is_rst(eng_is_rst),
    .eng_is_byte(eng_is_byte), .eng_tx(eng_tx), .busy_q(ctl_busy), .ptr_q(rd_ptr),
    .cfg_q(cfg_q), .data_q(data_q), .status(status)
  );

  owb_bit_engine #(
    .RSTL(RSTL), .RSTH(RSTH), .SHORT_AT(SHORT_AT), .PRES_AT(PRES_AT),
    .SLOT(SLOT), .LOW0(LOW0), .LOW1(LOW1), .SAMP_AT(SAMP_AT)
  ) u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .start_rst(eng_is_rst),
    .start_byte(eng_is_byte), .tx(eng_tx), .ow_sense(ow_sense),
    .ow_pull_low(ow_pull_low), .line_lvl(line_lvl), .done(eng_done), .rx(eng_rx),
    .presence(eng_pres), .short_flag(eng_short)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h18;
    else begin
      case (rd_ptr)
        SEL_CFG:  rd_data <= {4'h0, cfg_q};
        SEL_DATA: rd_data <= data_q;
        default:  rd_data <= status;
      endcase
    end
  end
endmodule

// File: rtl/owb_bridge_chk.sv
module owb_bridge_chk #(
  parameter int RSTL = 24000
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_valid,
  input logic       ow_pull_low,
  input logic [7:0] rd_data,
  input logic       ctl_busy,
  input logic [7:0] rd_ptr,
  input logic [3:0] cfg_q
);
  logic [31:0] low_run;

  always_ff @(posedge clk) begin
    if (rst) low_run <= '0;
    else if (ow_pull_low) low_run <= low_run + 1;
    else low_run <= '0;
  end

  // R5: line stays released while no operation runs
  assert_idle_released_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctl_busy && !$past(ctl_busy)) |-> !ow_pull_low);

  // R5: bytes written while busy do not touch configuration or selector
  assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl_busy && wr_valid) |=> ($stable(cfg_q) && $stable(rd_ptr)));

  // R2: configuration read-back has a zero upper nibble
  assert_cfg_nibble_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_ptr) == 8'hC3) |-> (rd_data[7:4] == 4'h0));

  // R4: selector only ever holds a legal code
  assert_ptr_legal_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_ptr == 8'hC3) || (rd_ptr == 8'hE1) || (rd_ptr == 8'hF0));

  // R14: no low pulse longer than the reset low time
  assert_low_bound_R14: assert property (@(posedge clk) disable iff (rst)
    ow_pull_low |-> (low_run < 32'(RSTL)));
endmodule

bind owb_bridge owb_bridge_chk #(.RSTL(RSTL)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .ow_pull_low(ow_pull_low),
  .rd_data(rd_data), .ctl_busy(ctl_busy), .rd_ptr(rd_ptr), .cfg_q(cfg_q)
);

// File: tb/tb_owb_bridge.sv
module tb_owb_bridge;
  localparam int P_RSTL = 40, P_RSTH = 40, P_SHORT = 2, P_PRES = 12;
  localparam int P_SLOT = 30, P_LOW0 = 20, P_LOW1 = 3, P_SAMP = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       ow_pull_low;
  logic       line_q = 1'b1;

  owb_bridge #(
    .RSTL(P_RSTL), .RSTH(P_RSTH), .SHORT_AT(P_SHORT), .PRES_AT(P_PRES),
    .SLOT(P_SLOT), .LOW0(P_LOW0), .LOW1(P_LOW1), .SAMP_AT(P_SAMP)
  ) dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_data(rd_data), .ow_pull_low(ow_pull_low), .ow_sense(line_q)
  );

  always #10 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  // bus device model
  logic       slave_present = 1'b1;
  logic       short_force = 1'b0;
  logic       slave_tx_en = 1'b0;
  logic [7:0] slave_tx = 8'h00;
  logic [7:0] slave_rx = 8'h00;
  logic       prev_pull = 1'b0;
  int         low_len = 0, last_low = 0, slot_cnt = -1, hold = 0, pres_wait = -1, pres_left = 0;

  always @(negedge clk) begin
    if (!ow_pull_low && prev_pull) begin
      last_low = low_len;
      if (low_len >= 30) begin
        slave_rx = 8'h00;
        slot_cnt = -1;
        hold = 0;
        if (slave_present) pres_wait = 5;
      end
    end
    if (ow_pull_low && !prev_pull) begin
      slot_cnt = 0;
      if (slave_tx_en && !slave_tx[0]) hold = 15;
      slave_tx = {slave_tx[0], slave_tx[7:1]};
    end
    low_len = ow_pull_low ? low_len + 1 : 0;
    if (slot_cnt >= 0) begin
      slot_cnt = slot_cnt + 1;
      if (slot_cnt == 12) begin
        slave_rx = {!ow_pull_low, slave_rx[7:1]};
        slot_cnt = -1;
      end
    end
    if (pres_wait > 0) pres_wait = pres_wait - 1;
    else if (pres_wait == 0) begin pres_wait = -1; pres_left = 20; end
    if (hold > 0) hold = hold - 1;
    if (pres_left > 0) pres_left = pres_left - 1;
    line_q = !(ow_pull_low || hold > 0 || pres_left > 0 || short_force);
    prev_pull = ow_pull_low;
  end

  // reference model of host-visible registers
  logic [3:0] m_cfg = 4'h0;
  logic [7:0] m_data = 8'h00, m_ptr = 8'hF0;
  logic       m_ppd = 0, m_sd = 0, m_sbr = 0, m_rstf = 1;

  function automatic logic [7:0] exp_status();
    return {2'b00, m_sbr, m_rstf, 1'b1, m_sd, m_ppd, 1'b0};
  endfunction

  function automatic logic [7:0] exp_reg(input logic [7:0] p);
    if (p == 8'hC3) return {4'h0, m_cfg};
    if (p == 8'hE1) return m_data;
    return exp_status();
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_idle();
    settle();
    for (int i = 0; i < 3000 && rd_data[0]; i++) @(negedge clk);
    settle();
  endtask

  task automatic select(input logic [7:0] p);
    wr(8'hE1); wr(p); settle();
    if (p == 8'hC3 || p == 8'hE1 || p == 8'hF0) m_ptr = p;
  endtask

  task automatic bus_reset();
    wr(8'hB4);
    @(negedge clk);
    check("R5 busy during reset", {7'b0, rd_data[0]}, 8'h01);
    wait_idle();
    m_ptr = 8'hF0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R5: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b, c;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    settle();

    // R1 reset state
    check("R1 status after reset", rd_data, 8'h18);
    check("R1 line released", {7'b0, ow_pull_low}, 8'h00);
    select(8'hC3); check("R1 cfg after reset", rd_data, 8'h00);
    select(8'hE1); check("R1 data after reset", rd_data, 8'h00);
    select(8'hF0);

    // R2 / R3 configuration writes
    for (int k = 0; k < 12; k++) begin
      c = 8'($urandom);
      b = (k % 2 == 0) ? {~c[3:0], c[3:0]} : c;
      if (b == {~c[3:0], c[3:0]} && k % 2 == 1) b = b ^ 8'h10;
      wr(8'hD2); wr(b); settle();
      if (b[7:4] == ~b[3:0]) begin
        m_cfg = b[3:0]; m_rstf = 0; m_ptr = 8'hC3;
        check("R2 accepted cfg readback", rd_data, {4'h0, b[3:0]});
      end else
        check("R3 rejected cfg no change", rd_data, exp_reg(m_ptr));
    end
    select(8'hF0);
    check("R2 startup flag cleared", rd_data, exp_status());

    // R4 selector codes
    for (int k = 0; k < 12; k++) begin
      case (k % 4)
        0: b = 8'hC3;
        1: b = 8'hE1;
        2: b = 8'hF0;
        default: begin b = 8'($urandom); if (b == 8'hC3 || b == 8'hE1 || b == 8'hF0) b = 8'h11; end
      endcase
      select(b);
      check("R4 selector", rd_data, exp_reg(m_ptr));
    end

    // R13 undefined command bytes
    select(8'hC3);
    wr(8'h78); wr(8'h00); wr(8'h5A); settle();
    check("R13 undefined commands ignored", rd_data, exp_reg(m_ptr));

    // R6 / R12 / R14 bus reset with presence
    slave_present = 1;
    bus_reset();
    m_ppd = 1; m_sd = 0;
    check("R6 R12 presence seen", rd_data, exp_status());
    check("R14 reset low width", 8'(last_low), 8'(P_RSTL));
    slave_present = 0;
    bus_reset();
    m_ppd = 0;
    check("R6 no presence", rd_data, exp_status());

    // R7 short
    short_force = 1;
    bus_reset();
    short_force = 0;
    settle();
    m_ppd = 1; m_sd = 1;
    check("R7 short flagged", rd_data, exp_status());
    slave_present = 1;
    bus_reset();
    m_ppd = 1; m_sd = 0;
    check("R7 short cleared", rd_data, exp_status());

    // R8 single slots
    slave_tx_en = 0;
    wr(8'h87); wr(8'h00); wait_idle();
    m_sbr = 0;
    check("R8 write 0 on line", {7'b0, slave_rx[7]}, 8'h00);
    check("R8 write 0 result", rd_data, exp_status());
    check("R14 zero slot width", 8'(last_low), 8'(P_LOW0));
    wr(8'h87); wr(8'h80); wait_idle();
    m_sbr = 1;
    check("R8 write 1 on line", {7'b0, slave_rx[7]}, 8'h01);
    check("R8 read slot 1", rd_data, exp_status());
    check("R14 one slot width", 8'(last_low), 8'(P_LOW1));
    slave_tx_en = 1; slave_tx = 8'h00;
    wr(8'h87); wr(8'hFF); wait_idle();
    m_sbr = 0;
    check("R8 read slot 0", rd_data, exp_status());
    slave_tx_en = 0;

    // R9 byte writes
    for (int k = 0; k < 6; k++) begin
      b = (k == 0) ? 8'h01 : 8'($urandom);
      wr(8'hA5); wr(b); wait_idle();
      check("R9 byte on line", slave_rx, b);
      check("R12 selector at status after write", rd_data, exp_status());
    end

    // R10 byte reads
    for (int k = 0; k < 6; k++) begin
      b = (k == 0) ? 8'h80 : 8'($urandom);
      slave_tx = b; slave_tx_en = 1;
      wr(8'h96); wait_idle();
      slave_tx_en = 0;
      m_data = b;
      select(8'hE1);
      check("R10 byte read", rd_data, b);
    end

    // R5 bytes ignored while busy
    select(8'hF0);
    slave_tx = 8'h3C; slave_tx_en = 1;
    wr(8'h96);
    wr(8'hE1); wr(8'hC3);
    wr(8'hD2); wr(8'h96);
    wait_idle();
    slave_tx_en = 0;
    m_data = 8'h3C;
    check("R5 selector unchanged by busy writes", rd_data, exp_status());
    select(8'hC3);
    check("R5 cfg unchanged by busy writes", rd_data, {4'h0, m_cfg});

    // R11 device reset
    wr(8'hD2); wr(8'h5A); settle();
    m_cfg = 4'hA; m_rstf = 0; m_ptr = 8'hC3;
    check("R2 cfg before device reset", rd_data, 8'h0A);
    wr(8'hF0); settle();
    m_cfg = 0; m_data = 0; m_ppd = 0; m_sd = 0; m_sbr = 0; m_rstf = 1; m_ptr = 8'hF0;
    check("R11 status after device reset", rd_data, 8'h18);
    select(8'hC3); check("R11 cfg cleared", rd_data, 8'h00);
    select(8'hE1); check("R11 data cleared", rd_data, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule